// File: doc/BRIEF.md
# Compact Branch Decode and Resolve

This block looks at one 32-bit instruction word, together with the address of that instruction and the two register values already fetched for it. It recognises the compact compare-and-branch group. Recognition uses the primary opcode and also how the two register-number fields relate to each other: one of them is zero, they are equal, they differ, or one is numerically smaller. For a recognised branch the block evaluates the condition on the operands and forms the PC-relative target. It reports whether the branch is taken and raises a flush request for the sequential successor, because these branches have no delay slot.

Several branches share one primary opcode. Decoding the opcode alone would therefore misclassify them. Any word that shares an opcode with the group but fails the field constraints is rejected, and all outputs stay quiet.

All outputs can be registered, so that every result appears one clock after its inputs with all fields aligned. This is the default. They can also be combinational.

Top module: `cbr_top`

## Requirements
- R1: In the long form, bits [25:21] are register field T, bits [20:16] are register field S, and bits [15:0] are a 16-bit offset. In the short form, bits [25:21] are field S and bits [20:0] are a 21-bit offset. `rsVal` carries the value of register S and `rtVal` carries the value of register T.
- R2: Opcode 6'b111101 with T nonzero decodes as follows. S zero gives kind 1, taken when signed T<=0. S equal to T gives kind 2, taken when signed T>=0. Any other S gives kind 3, taken when signed S>=T. When T is zero the word is not a branch.
- R3: Opcode 6'b110101 with T nonzero decodes as follows. S zero gives kind 4, taken when signed T>0. S equal to T gives kind 5, taken when signed T<0. Any other S gives kind 6, taken when signed S<T. When T is zero the word is not a branch.
- R4: Opcode 6'b110000 gives kind 7, taken when unsigned S>=T. Opcode 6'b111000 gives kind 8, taken when unsigned S<T. Both need S and T nonzero and different field numbers.
- R5: Opcode 6'b011101 gives kind 9, taken when the operands are equal. Opcode 6'b011111 gives kind 10, taken when they differ. Both need field S nonzero and numerically smaller than field T.
- R6: Short-form opcode 6'b100000 gives kind 11, taken when S is zero. Short-form opcode 6'b101000 gives kind 12, taken when S is nonzero. Both need field S nonzero.
- R7: Signed kinds compare two's-complement values. Kinds 7 and 8 compare raw magnitudes.
- R8: For a valid branch, `brTarget` = pc + 4 + sign-extended (offset << 2). The displacement is 18 bits for the long form and 23 bits for the short form.
- R9: `flushNext` equals `brTaken`, and `brTaken` is only high when `brValid` is high.
- R10: Any word outside R2 to R6 drives `brValid`, `brTaken` and `flushNext` low and `brKind` to 0.
- R11: With the default registered outputs, each result appears one clock edge after its inputs, with all fields aligned. While reset is active, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| rsVal | input | XLEN | Value of register field S |
| rtVal | input | XLEN | Value of register field T |
| brValid | output | 1 | Word is a compact branch |
| brKind | output | 4 | Branch kind code (0 = none) |
| brTaken | output | 1 | Condition true |
| flushNext | output | 1 | Discard the sequential successor |
| brTarget | output | XLEN | PC-relative target |

## Verification
Field decode and operand comparison meet in the same cycle when the register numbers are equal. Under opcode 111101 or 110101, S equal to T must select the compare-with-zero kind, even though the operand values are then equal and a register-register compare would give a different answer. The bench provokes this with matching field numbers and with negative, zero and positive operands. It judges both the kind code and the taken result against its own model. A second collision is between the field order constraint of the equality pair and operand equality: the bench issues equal operands with S greater than or equal to T and expects no branch.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [3:0] {
    KIND_NONE = 4'd0,
    KIND_LEZ  = 4'd1,
    KIND_GEZ  = 4'd2,
    KIND_GE   = 4'd3,
    KIND_GTZ  = 4'd4,
    KIND_LTZ  = 4'd5,
    KIND_LT   = 4'd6,
    KIND_GEU  = 4'd7,
    KIND_LTU  = 4'd8,
    KIND_EQ   = 4'd9,
    KIND_NE   = 4'd10,
    KIND_EQZ  = 4'd11,
    KIND_NEZ  = 4'd12
  } brKind_e;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_LTS = 3'd2,
    REL_GES = 3'd3,
    REL_LES = 3'd4,
    REL_GTS = 3'd5,
    REL_LTU = 3'd6,
    REL_GEU = 3'd7
  } relOp_e;

  // strobes from decode control to the compare/target datapath
  typedef struct packed {
    logic   valid;
    logic   wideOff;
    logic   aIsRt;
    logic   bIsZero;
    relOp_e rel;
  } cbrCtl_t;

  localparam logic [5:0] OP_POS_SGN = 6'b111101;
  localparam logic [5:0] OP_NEG_SGN = 6'b110101;
  localparam logic [5:0] OP_GEU     = 6'b110000;
  localparam logic [5:0] OP_LTU     = 6'b111000;
  localparam logic [5:0] OP_EQ      = 6'b011101;
  localparam logic [5:0] OP_NE      = 6'b011111;
  localparam logic [5:0] OP_EQZ     = 6'b100000;
  localparam logic [5:0] OP_NEZ     = 6'b101000;

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [31:0] instr,
  output cbrCtl_t     ctl,
  output brKind_e     kind
);
  localparam int FIELD_W = 5;

  logic [5:0]         opcode;
  logic [FIELD_W-1:0] hiField;
  logic [FIELD_W-1:0] loField;
  logic               hiZero;
  logic               loZero;
  logic               sameField;
  logic               loBelowHi;

  assign opcode    = instr[31:26];
  assign hiField   = instr[25:21];
  assign loField   = instr[20:16];
  assign hiZero    = (hiField == '0);
  assign loZero    = (loField == '0);
  assign sameField = (hiField == loField);
  assign loBelowHi = (loField < hiField);

  always_comb begin
    ctl  = '{valid: 1'b0, wideOff: 1'b0, aIsRt: 1'b0, bIsZero: 1'b0, rel: REL_EQ};
    kind = KIND_NONE;
    unique case (opcode)
      OP_POS_SGN: begin
        if (!hiZero) begin
          ctl.valid = 1'b1;
          if (loZero) begin
            kind = KIND_LEZ;  ctl.aIsRt = 1'b1; ctl.bIsZero = 1'b1; ctl.rel = REL_LES;
          end else if (sameField) begin
            kind = KIND_GEZ;  ctl.aIsRt = 1'b1; ctl.bIsZero = 1'b1; ctl.rel = REL_GES;
          end else begin
            kind = KIND_GE;   ctl.rel = REL_GES;
          end
        end
      end
      OP_NEG_SGN: begin
        if (!hiZero) begin
          ctl.valid = 1'b1;
          if (loZero) begin
            kind = KIND_GTZ;  ctl.aIsRt = 1'b1; ctl.bIsZero = 1'b1; ctl.rel = REL_GTS;
          end else if (sameField) begin
            kind = KIND_LTZ;  ctl.aIsRt = 1'b1; ctl.bIsZero = 1'b1; ctl.rel = REL_LTS;
          end else begin
            kind = KIND_LT;   ctl.rel = REL_LTS;
          end
        end
      end
      OP_GEU, OP_LTU: begin
        if (!hiZero && !loZero && !sameField) begin
          ctl.valid = 1'b1;
          kind      = (opcode == OP_GEU) ? KIND_GEU : KIND_LTU;
          ctl.rel   = (opcode == OP_GEU) ? REL_GEU : REL_LTU;
        end
      end
      OP_EQ, OP_NE: begin
        if (!loZero && loBelowHi) begin
          ctl.valid = 1'b1;
          kind      = (opcode == OP_EQ) ? KIND_EQ : KIND_NE;
          ctl.rel   = (opcode == OP_EQ) ? REL_EQ : REL_NE;
        end
      end
      OP_EQZ, OP_NEZ: begin
        if (!hiZero) begin
          ctl.valid   = 1'b1;
          ctl.wideOff = 1'b1;
          ctl.bIsZero = 1'b1;
          kind        = (opcode == OP_EQZ) ? KIND_EQZ : KIND_NEZ;
          ctl.rel     = (opcode == OP_EQZ) ? REL_EQ : REL_NE;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cbr_datapath.sv
module cbr_datapath
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cbrCtl_t         ctl,
  input  logic [20:0]     offBits,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic            taken,
  output logic [XLEN-1:0] target
);
  localparam int NARROW_W = 16 + 2;
  localparam int WIDE_W   = 21 + 2;
  localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

  logic [XLEN-1:0] opA;
  logic [XLEN-1:0] opB;
  logic            isEq;
  logic            isLtS;
  logic            isLtU;
  logic            cond;
  logic [NARROW_W-1:0] narrowDisp;
  logic [WIDE_W-1:0]   wideDisp;
  logic [XLEN-1:0]     disp;

  assign opA = ctl.aIsRt ? rtVal : rsVal;
  assign opB = ctl.bIsZero ? '0 : rtVal;

  assign isEq  = (opA == opB);
  assign isLtS = ($signed(opA) < $signed(opB));
  assign isLtU = (opA < opB);

  always_comb begin
    unique case (ctl.rel)
      REL_EQ:  cond = isEq;
      REL_NE:  cond = !isEq;
      REL_LTS: cond = isLtS;
      REL_GES: cond = !isLtS;
      REL_LES: cond = isLtS || isEq;
      REL_GTS: cond = !isLtS && !isEq;
      REL_LTU: cond = isLtU;
      REL_GEU: cond = !isLtU;
      default: cond = 1'b0;
    endcase
  end

  assign taken = ctl.valid && cond;

  assign narrowDisp = {offBits[15:0], 2'b00};
  assign wideDisp   = {offBits, 2'b00};
  assign disp = ctl.wideOff ? XLEN'($signed(wideDisp)) : XLEN'($signed(narrowDisp));

  assign target = pc + INSTR_BYTES + disp;
endmodule

// File: rtl/cbr_top.sv
module cbr_top
  import cbr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic            brValid,
  output logic [3:0]      brKind,
  output logic            brTaken,
  output logic            flushNext,
  output logic [XLEN-1:0] brTarget
);
  cbrCtl_t         ctl;
  brKind_e         kindC;
  logic            takenC;
  logic [XLEN-1:0] targetC;

  cbr_decode u_decode (
    .instr (instr),
    .ctl   (ctl),
    .kind  (kindC)
  );

  cbr_datapath #(.XLEN(XLEN)) u_datapath (
    .ctl     (ctl),
    .offBits (instr[20:0]),
    .pc      (pc),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .taken   (takenC),
    .target  (targetC)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          brValid   <= 1'b0;
          brKind    <= 4'd0;
          brTaken   <= 1'b0;
          flushNext <= 1'b0;
          brTarget  <= '0;
        end else begin
          brValid   <= ctl.valid;
          brKind    <= kindC;
          brTaken   <= takenC;
          flushNext <= takenC;
          brTarget  <= targetC;
        end
      end
    end else begin : g_comb
      assign brValid   = ctl.valid;
      assign brKind    = kindC;
      assign brTaken   = takenC;
      assign flushNext = takenC;
      assign brTarget  = targetC;
    end
  endgenerate
endmodule

// File: rtl/cbr_chk.sv
module cbr_chk #(
  parameter int XLEN    = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rsVal,
  input logic            brValid,
  input logic [3:0]      brKind,
  input logic            brTaken,
  input logic            flushNext
);
  logic [31:0]     instrD;
  logic [XLEN-1:0] rsD;

  generate
    if (OUT_REG) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rstN) begin
          instrD <= '0;
          rsD    <= '0;
        end else begin
          instrD <= instr;
          rsD    <= rsVal;
        end
      end
    end else begin : g_now
      assign instrD = instr;
      assign rsD    = rsVal;
    end
  endgenerate

  // R9
  taken_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> brValid);

  // R9
  flush_follows_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushNext == brTaken);

  // R10
  reject_is_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |-> (brKind == 4'd0 && !flushNext));

  // R2
  t_zero_rejected_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((instrD[31:26] == 6'b111101 || instrD[31:26] == 6'b110101) && instrD[25:21] == 5'd0)
      |-> !brValid);

  // R5
  eq_field_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && (brKind == 4'd9 || brKind == 4'd10))
      |-> (instrD[20:16] != 5'd0 && instrD[20:16] < instrD[25:21]));

  // R6
  zero_test_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brKind == 4'd11) |-> (brTaken == (rsD == '0)));
endmodule

bind cbr_top cbr_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_cbr_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instr     (instr),
  .rsVal     (rsVal),
  .brValid   (brValid),
  .brKind    (brKind),
  .brTaken   (brTaken),
  .flushNext (flushNext)
);

// File: tb/tb_cbr_top.sv
module tb_cbr_top;
  localparam int XLEN = 32;
  localparam time CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] pc = '0;
  logic [XLEN-1:0] rsVal = '0;
  logic [XLEN-1:0] rtVal = '0;
  logic            brValid;
  logic [3:0]      brKind;
  logic            brTaken;
  logic            flushNext;
  logic [XLEN-1:0] brTarget;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_top #(.XLEN(XLEN), .OUT_REG(1'b1)) dut (
    .clk(clk), .rstN(rstN), .instr(instr), .pc(pc), .rsVal(rsVal), .rtVal(rtVal),
    .brValid(brValid), .brKind(brKind), .brTaken(brTaken),
    .flushNext(flushNext), .brTarget(brTarget)
  );

  function automatic logic [31:0] mkL(logic [5:0] op, logic [4:0] t, logic [4:0] s, logic [15:0] off);
    return {op, t, s, off};
  endfunction

  function automatic logic [31:0] mkS(logic [5:0] op, logic [4:0] s, logic [20:0] off);
    return {op, s, off};
  endfunction

  // behavioural model written from the requirement list
  function automatic void model(input logic [31:0] w, input logic [31:0] p,
                                input logic [31:0] sv, input logic [31:0] tv,
                                output int k, output bit tk, output logic [31:0] tg);
    logic [5:0] op;
    logic [4:0] t, s;
    bit wide;
    op = w[31:26]; t = w[25:21]; s = w[20:16];
    k = 0; tk = 0; wide = 0;
    case (op)
      6'b111101: if (t != 0) begin
        if (s == 0)      begin k = 1; tk = ($signed(tv) <= 0); end
        else if (s == t) begin k = 2; tk = ($signed(tv) >= 0); end
        else             begin k = 3; tk = ($signed(sv) >= $signed(tv)); end
      end
      6'b110101: if (t != 0) begin
        if (s == 0)      begin k = 4; tk = ($signed(tv) > 0); end
        else if (s == t) begin k = 5; tk = ($signed(tv) < 0); end
        else             begin k = 6; tk = ($signed(sv) < $signed(tv)); end
      end
      6'b110000: if (t != 0 && s != 0 && s != t) begin k = 7; tk = (sv >= tv); end
      6'b111000: if (t != 0 && s != 0 && s != t) begin k = 8; tk = (sv < tv); end
      6'b011101: if (s != 0 && s < t) begin k = 9;  tk = (sv == tv); end
      6'b011111: if (s != 0 && s < t) begin k = 10; tk = (sv != tv); end
      6'b100000: if (t != 0) begin k = 11; tk = (sv == 0); wide = 1; end
      6'b101000: if (t != 0) begin k = 12; tk = (sv != 0); wide = 1; end
      default: ;
    endcase
    if (wide) tg = p + 32'd4 + {{9{w[20]}}, w[20:0], 2'b00};
    else      tg = p + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
  endfunction

  task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // drive one word, wait for the output register, compare every output
  task automatic run(string tag, logic [31:0] w, logic [31:0] p, logic [31:0] sv, logic [31:0] tv);
    int k; bit tk; logic [31:0] tg; bit bad;
    model(w, p, sv, tv, k, tk, tg);
    @(negedge clk);
    instr = w; pc = p; rsVal = sv; rtVal = tv;
    @(negedge clk);
    checks++;
    bad = 0;
    if (brValid !== (k != 0)) begin fail_line(tag, "valid", 32'(brValid), 32'(k != 0)); bad = 1; end
    if (!bad && brKind !== 4'(k)) begin fail_line(tag, "kind", 32'(brKind), 32'(k)); bad = 1; end
    if (!bad && brTaken !== tk) begin fail_line(tag, "taken", 32'(brTaken), 32'(tk)); bad = 1; end
    if (!bad && flushNext !== tk) begin fail_line(tag, "flush", 32'(flushNext), 32'(tk)); bad = 1; end
    if (!bad && k != 0 && brTarget !== tg) fail_line(tag, "target", brTarget, tg);
  endtask

  task automatic t_reset();
    checks++;
    if ({brValid, brKind, brTaken, flushNext} !== 7'd0 || brTarget !== '0)
      fail_line("R11", "reset outputs", {25'd0, brValid, brKind, brTaken, flushNext}, 32'd0);
  endtask

  task automatic t_pos_sign();
    run("R2", mkL(6'b111101, 5'd3, 5'd0, 16'h0010), 32'h1000, 32'h5, 32'h0);
    run("R2", mkL(6'b111101, 5'd3, 5'd0, 16'h0010), 32'h1000, 32'h5, 32'h1);
    run("R2", mkL(6'b111101, 5'd7, 5'd7, 16'h0020), 32'h2000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R2", mkL(6'b111101, 5'd7, 5'd7, 16'h0020), 32'h2000, 32'h0, 32'h0);
    run("R2", mkL(6'b111101, 5'd4, 5'd9, 16'h0004), 32'h3000, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R2", mkL(6'b111101, 5'd0, 5'd9, 16'h0004), 32'h3000, 32'h9, 32'h1);
  endtask

  task automatic t_neg_sign();
    run("R3", mkL(6'b110101, 5'd2, 5'd0, 16'h0008), 32'h1000, 32'h0, 32'h7FFF_FFFF);
    run("R3", mkL(6'b110101, 5'd2, 5'd0, 16'h0008), 32'h1000, 32'h0, 32'h0);
    run("R3", mkL(6'b110101, 5'd6, 5'd6, 16'h0008), 32'h1000, 32'h8000_0000, 32'h8000_0000);
    run("R3", mkL(6'b110101, 5'd6, 5'd6, 16'h0008), 32'h1000, 32'h0, 32'h0);
    run("R3", mkL(6'b110101, 5'd5, 5'd1, 16'h0008), 32'h1000, 32'hFFFF_FFFF, 32'h0);
    run("R3", mkL(6'b110101, 5'd0, 5'd1, 16'h0008), 32'h1000, 32'h0, 32'h5);
  endtask

  task automatic t_unsigned();
    run("R4", mkL(6'b110000, 5'd2, 5'd3, 16'h0001), 32'h4000, 32'hFFFF_FFFF, 32'h1);
    run("R4", mkL(6'b111000, 5'd2, 5'd3, 16'h0001), 32'h4000, 32'hFFFF_FFFF, 32'h1);
    run("R4", mkL(6'b111000, 5'd2, 5'd3, 16'h0001), 32'h4000, 32'h7FFF_FFFF, 32'h8000_0000);
    run("R4", mkL(6'b110000, 5'd3, 5'd3, 16'h0001), 32'h4000, 32'h5, 32'h1);
    run("R4", mkL(6'b111000, 5'd3, 5'd0, 16'h0001), 32'h4000, 32'h0, 32'h1);
  endtask

  task automatic t_equality();
    run("R5", mkL(6'b011101, 5'd8, 5'd2, 16'h0040), 32'h5000, 32'h1234, 32'h1234);
    run("R5", mkL(6'b011111, 5'd8, 5'd2, 16'h0040), 32'h5000, 32'h1234, 32'h1234);
    run("R5", mkL(6'b011111, 5'd8, 5'd2, 16'h0040), 32'h5000, 32'h1234, 32'h1235);
    run("R5", mkL(6'b011101, 5'd2, 5'd8, 16'h0040), 32'h5000, 32'h1234, 32'h1234);
    run("R5", mkL(6'b011101, 5'd4, 5'd4, 16'h0040), 32'h5000, 32'h1, 32'h1);
    run("R5", mkL(6'b011111, 5'd4, 5'd0, 16'h0040), 32'h5000, 32'h0, 32'h1);
  endtask

  task automatic t_zero_wide();
    run("R6", mkS(6'b100000, 5'd4, 21'h000010), 32'h6000, 32'h0, 32'h99);
    run("R6", mkS(6'b100000, 5'd4, 21'h000010), 32'h6000, 32'h1, 32'h0);
    run("R6", mkS(6'b101000, 5'd4, 21'h000010), 32'h6000, 32'h8000_0000, 32'h0);
    run("R6", mkS(6'b101000, 5'd0, 21'h000010), 32'h6000, 32'h8, 32'h0);
  endtask

  task automatic t_sign_edges();
    run("R7", mkL(6'b110101, 5'd2, 5'd1, 16'h0), 32'h0, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R7", mkL(6'b111000, 5'd2, 5'd1, 16'h0), 32'h0, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R7", mkL(6'b111101, 5'd2, 5'd1, 16'h0), 32'h0, 32'hFFFF_FFFF, 32'h0);
    run("R7", mkL(6'b110000, 5'd2, 5'd1, 16'h0), 32'h0, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_targets();
    run("R8", mkL(6'b011101, 5'd9, 5'd1, 16'h7FFF), 32'h0010_0000, 32'h0, 32'h0);
    run("R8", mkL(6'b011101, 5'd9, 5'd1, 16'h8000), 32'h0010_0000, 32'h0, 32'h0);
    run("R8", mkS(6'b100000, 5'd1, 21'h0FFFFF), 32'h0100_0000, 32'h0, 32'h0);
    run("R8", mkS(6'b100000, 5'd1, 21'h100000), 32'h0100_0000, 32'h0, 32'h0);
    run("R8", mkL(6'b110101, 5'd2, 5'd0, 16'hFFFF), 32'h0000_0008, 32'h0, 32'h1);
  endtask

  task automatic t_rejects();
    run("R10", mkL(6'b000000, 5'd3, 5'd4, 16'h0), 32'h0, 32'h1, 32'h2);
    run("R10", mkL(6'b110101, 5'd0, 5'd0, 16'h0), 32'h0, 32'h0, 32'h0);
    run("R10", mkL(6'b011111, 5'd0, 5'd0, 16'h0), 32'h0, 32'h0, 32'h1);
    run("R9", mkL(6'b011111, 5'd3, 5'd1, 16'h0), 32'h0, 32'h0, 32'h1);
  endtask

  // R11: outputs must keep the previous result until the next edge
  task automatic t_latency();
    run("R11", mkS(6'b101000, 5'd1, 21'h4), 32'h100, 32'h1, 32'h0);
    @(negedge clk);
    instr = mkL(6'b000000, 5'd0, 5'd0, 16'h0);
    #1;
    checks++;
    if (brValid !== 1'b1 || brKind !== 4'd12)
      fail_line("R11", "held before edge", {27'd0, brValid, brKind}, {27'd0, 1'b1, 4'd12});
    @(negedge clk);
    checks++;
    if (brValid !== 1'b0 || brTaken !== 1'b0)
      fail_line("R11", "after edge", {30'd0, brValid, brTaken}, 32'd0);
  endtask

  task automatic t_random();
    logic [5:0] ops [8] = '{6'b111101, 6'b110101, 6'b110000, 6'b111000,
                            6'b011101, 6'b011111, 6'b100000, 6'b101000};
    logic [31:0] edges [4] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0};
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w, sv, tv;
      w = $urandom;
      w[31:26] = ops[$urandom % 8];
      if (i % 5 == 0) w[20:16] = w[25:21];
      if (i % 7 == 0) w[20:16] = 5'd0;
      sv = (i % 3 == 0) ? edges[$urandom % 4] : $urandom;
      tv = (i % 4 == 0) ? edges[$urandom % 4] : ((i % 6 == 0) ? sv : $urandom);
      run("R1", w, $urandom & 32'hFFFF_FFFC, sv, tv);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_pos_sign();
    t_neg_sign();
    t_unsigned();
    t_equality();
    t_zero_wide();
    t_sign_edges();
    t_targets();
    t_rejects();
    t_latency();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule